// File: doc/BRIEF.md
# Patrol Memory Scrub Engine

This engine runs in the background and sweeps every cache line of memory at a steady rate. At each sweep step it issues a scrub read so that latent correctable errors are found and repaired before they build up. It holds a scrub pointer made of a channel index, a rank index and a line index, and an interval timer. When the timer runs out, the engine presents one read request on a valid/ready port. It holds that request until the request is accepted, then steps the pointer to the next line. The responses to these reads, and any error handling after them, belong to a separate unit.

The sweep covers all lines of all ranks of one channel before it moves to the next channel that is up. A channel can be reported down at any time. If the channel under the pointer goes down, the pointer jumps to the next channel that is up and keeps its rank and line. The rest of the sweep of the dead channel is abandoned. A one-cycle pulse marks the end of each full pass over the channels that are up.

The controller has three named states. IDLE means scrubbing is disabled or no channel is up. WAIT means the interval timer is counting. ISSUE means a request is presented on the port. The transitions are:
- start, IDLE to WAIT, when the engine is enabled and at least one channel is up.
- stop, WAIT to IDLE, when the engine is disabled or every channel is down.
- expire, WAIT to ISSUE, when the interval elapses.
- accept, ISSUE to WAIT or to IDLE, when the request is accepted.
- withdraw, ISSUE to WAIT, when the channel of the pending request goes down before the request is accepted.

Top module: `patrol_scrub_engine`

## Requirements
- R1: While `scrub_en` is low, no new request is raised. A request already presented stays presented until it is accepted. After that the port stays idle.
- R2: During and after reset, `req_valid` and `pass_done` are 0 and the pointer is at channel 0, rank 0, line 0.
- R3: With `req_ready` held high, `req_valid` rises exactly INTERVAL cycles after the cycle of the previous accepted handshake.
- R4: A presented request keeps `req_valid` high with an unchanged `req_chan`/`req_rank`/`req_line` until `req_ready` is sampled high. The next interval is counted from that late acceptance, so back pressure lowers the rate.
- R5: After each accepted request, the pointer steps through the lines in this order:
  - The line index goes up by 1.
  - After line LINES-1, the line index returns to 0 and the rank index goes up by 1.
  - After rank RANKS-1, the rank returns to 0 and the channel moves to the next channel that is up, searching in rising index order and wrapping at NUM_CH-1.
- R6: A channel whose bit in `chan_up` is 0 is skipped when the sweep moves to the next channel.
- R7: If the channel under the pointer goes down, the pointer moves to the next channel that is up and keeps its rank and line. A pending request for the dead channel is withdrawn, and a new full interval starts.
- R8: `pass_done` is high for exactly one cycle, the cycle after acceptance of the last line of the last rank, whenever the channel search wraps to an index less than or equal to the current one.
- R9: While every bit of `chan_up` is 0, no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scrub_en | input | 1 | Enables the patrol sweep |
| chan_up | input | NUM_CH | Bit i high: channel i is online |
| req_valid | output | 1 | Scrub read request presented |
| req_ready | input | 1 | Downstream accepts the request this cycle |
| req_chan | output | CH_W | Channel index of the request |
| req_rank | output | RANK_W | Rank index of the request |
| req_line | output | LINE_W | Cache line index within the rank |
| pass_done | output | 1 | One-cycle pulse at the end of a full pass |

## Verification
The sweep is first driven with `req_ready` held high. This checks the exact interval spacing and the line/rank/channel order across full passes, including the wrap pulse. Seeded random back pressure then separates the "count from acceptance" rule from a free-running timer and checks that a pending request stays stable. Directed phases take channels down in several ways:
- A non-current channel goes down, which checks skipping.
- The current channel goes down while a request waits, which checks withdrawal and that rank and line are kept.
- Every channel goes down at once.
Enable is also dropped both while the engine waits and while a request is pending, which separates "stop raising" from "drop what is presented".

// File: rtl/scrub_pkg.sv
package scrub_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_ISSUE = 2'd2
    } scrub_state_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/scrub_interval_timer.sv
module scrub_interval_timer #(
    parameter int INTERVAL = 16384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    output logic expire
);
    localparam int CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 2);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (count_en) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    assign expire = count_en && (cnt_q == LAST);

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_en |-> (cnt_q <= LAST)); // R3

endmodule

// File: rtl/scrub_pointer.sv
module scrub_pointer #(
    parameter int NUM_CH = 2,
    parameter int RANKS  = 4,
    parameter int LINES  = 1024,
    parameter int CH_W   = 1,
    parameter int RANK_W = 2,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] chan_up,
    input  logic              advance,
    output logic [CH_W-1:0]   ch_q,
    output logic [RANK_W-1:0] rank_q,
    output logic [LINE_W-1:0] line_q,
    output logic              cur_up,
    output logic              any_up,
    output logic              pass_q
);
    localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES - 1);
    localparam logic [RANK_W-1:0] RANK_LAST = RANK_W'(RANKS - 1);

    logic [CH_W-1:0] nxt_ch;
    logic            nxt_wraps;
    logic            found;
    logic            end_of_chan;

    always_comb begin
        nxt_ch    = ch_q;
        nxt_wraps = 1'b0;
        found     = 1'b0;
        for (int k = 1; k <= NUM_CH; k++) begin
            int idx;
            idx = (int'(ch_q) + k) % NUM_CH;
            if (!found && chan_up[idx]) begin
                found     = 1'b1;
                nxt_ch    = CH_W'(idx);
                nxt_wraps = (idx <= int'(ch_q));
            end
        end
    end

    assign cur_up      = chan_up[ch_q];
    assign any_up      = |chan_up;
    assign end_of_chan = (line_q == LINE_LAST) && (rank_q == RANK_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q   <= '0;
            rank_q <= '0;
            line_q <= '0;
            pass_q <= 1'b0;
        end else begin
            pass_q <= 1'b0;
            if (advance) begin
                if (line_q == LINE_LAST) begin
                    line_q <= '0;
                    if (rank_q == RANK_LAST) begin
                        rank_q <= '0;
                        ch_q   <= nxt_ch;
                        pass_q <= nxt_wraps;
                    end else begin
                        rank_q <= rank_q + 1'b1;
                    end
                end else begin
                    line_q <= line_q + 1'b1;
                end
            end else if (!cur_up && any_up) begin
                ch_q <= nxt_ch;
            end
        end
    end

    AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && line_q != LINE_LAST) |=>
            (line_q == $past(line_q) + 1'b1) && $stable(rank_q) && $stable(ch_q)); // R5

    AST_MIGRATE_KEEPS_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !cur_up && any_up) |=>
            $stable(rank_q) && $stable(line_q) && (ch_q != $past(ch_q))); // R7

    AST_PASS_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        pass_q |-> (rank_q == '0) && (line_q == '0) && $past(advance && end_of_chan)); // R8

    AST_SKIP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && end_of_chan && any_up) |=> chan_up[ch_q] || !$stable(chan_up)); // R6

endmodule

// File: rtl/scrub_ctrl_fsm.sv
module scrub_ctrl_fsm
    import scrub_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scrub_en,
    input  logic any_up,
    input  logic cur_up,
    input  logic expire,
    input  logic req_ready,
    output logic req_valid,
    output logic advance,
    output logic count_en
);
    scrub_state_e state_q;
    scrub_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (scrub_en && any_up) state_d = ST_WAIT;           // start
            end
            ST_WAIT: begin
                if (!scrub_en || !any_up) state_d = ST_IDLE;         // stop
                else if (expire)          state_d = ST_ISSUE;        // expire
            end
            ST_ISSUE: begin
                if (req_ready) begin                                  // accept
                    state_d = (scrub_en && any_up) ? ST_WAIT : ST_IDLE;
                end else if (!cur_up) begin
                    state_d = ST_WAIT;                                // withdraw
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        req_valid = (state_q == ST_ISSUE);
        advance   = (state_q == ST_ISSUE) && req_ready;
        count_en  = (state_q == ST_WAIT);
    end

    AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!scrub_en && state_q != ST_ISSUE) |=> (state_q != ST_ISSUE)); // R1

    AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ISSUE && !req_ready && cur_up) |=> (state_q == ST_ISSUE)); // R4

    AST_NO_REQ_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_up && state_q != ST_ISSUE) |=> (state_q != ST_ISSUE)); // R9

endmodule

// File: rtl/patrol_scrub_engine.sv
module patrol_scrub_engine #(
    parameter int NUM_CH   = 2,
    parameter int RANKS    = 4,
    parameter int LINES    = 1024,
    parameter int INTERVAL = 16384,
    localparam int CH_W    = scrub_pkg::idx_width(NUM_CH),
    localparam int RANK_W  = scrub_pkg::idx_width(RANKS),
    localparam int LINE_W  = scrub_pkg::idx_width(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scrub_en,
    input  logic [NUM_CH-1:0] chan_up,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [CH_W-1:0]   req_chan,
    output logic [RANK_W-1:0] req_rank,
    output logic [LINE_W-1:0] req_line,
    output logic              pass_done
);
    logic advance;
    logic count_en;
    logic expire;
    logic cur_up;
    logic any_up;

    scrub_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en),
        .expire   (expire)
    );

    scrub_pointer #(
        .NUM_CH (NUM_CH),
        .RANKS  (RANKS),
        .LINES  (LINES),
        .CH_W   (CH_W),
        .RANK_W (RANK_W),
        .LINE_W (LINE_W)
    ) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .chan_up (chan_up),
        .advance (advance),
        .ch_q    (req_chan),
        .rank_q  (req_rank),
        .line_q  (req_line),
        .cur_up  (cur_up),
        .any_up  (any_up),
        .pass_q  (pass_done)
    );

    scrub_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scrub_en  (scrub_en),
        .any_up    (any_up),
        .cur_up    (cur_up),
        .expire    (expire),
        .req_ready (req_ready),
        .req_valid (req_valid),
        .advance   (advance),
        .count_en  (count_en)
    );

    AST_PAYLOAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && cur_up) |=>
            req_valid && $stable(req_chan) && $stable(req_rank) && $stable(req_line)); // R4

    AST_PASS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |=> !pass_done); // R8

endmodule

// File: tb/patrol_scrub_engine_bench.sv
`timescale 1ns/1ps
module patrol_scrub_engine_bench;
    localparam int NUM_CH   = 2;
    localparam int RANKS    = 2;
    localparam int LINES    = 4;
    localparam int INTERVAL = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scrub_en = 1'b0;
    logic [1:0] chan_up = 2'b11;
    logic       req_valid;
    logic       req_ready = 1'b0;
    logic       req_chan;
    logic       req_rank;
    logic [1:0] req_line;
    logic       pass_done;

    always #2.5 clk = ~clk;

    patrol_scrub_engine #(
        .NUM_CH(NUM_CH), .RANKS(RANKS), .LINES(LINES), .INTERVAL(INTERVAL)
    ) u_patrol_scrub_engine (
        .clk(clk), .rst_n(rst_n), .scrub_en(scrub_en), .chan_up(chan_up),
        .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
        .req_rank(req_rank), .req_line(req_line), .pass_done(pass_done)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit run      = 0;
    bit finished = 0;
    int mode     = 0;   // 0 ready high, 1 random, 2 ready low
    int cyc      = 0;
    int last_acc = 0;
    bit skip_t   = 1;
    bit prev_valid = 0;
    bit exp_pass = 0;
    int acc_cnt  = 0;
    int m_ch = 0, m_rank = 0, m_line = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("[TB] FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int next_up_ch(input int cur, input logic [1:0] up);
        for (int k = 1; k <= NUM_CH; k++) begin
            if (up[(cur + k) % NUM_CH]) return (cur + k) % NUM_CH;
        end
        return cur;
    endfunction

    function automatic int pack_ptr(input int c, input int r, input int l);
        return c * 100 + r * 10 + l;
    endfunction

    // Monitor, model and ready driver, all at the falling edge
    always @(negedge clk) begin
        if (run) begin
            bit rdy;
            bit acc;
            cyc++;
            chk(pass_done == exp_pass, "R8 pass_done", pass_done, exp_pass);
            exp_pass = 0;
            if (req_valid) begin
                chk(pack_ptr(req_chan, req_rank, req_line) == pack_ptr(m_ch, m_rank, m_line),
                    "R5/R7 payload", pack_ptr(req_chan, req_rank, req_line),
                    pack_ptr(m_ch, m_rank, m_line));
                if (!prev_valid) begin
                    if (!skip_t)
                        chk(cyc == last_acc + INTERVAL, "R3/R4 spacing", cyc - last_acc, INTERVAL);
                    skip_t = 0;
                end
            end
            prev_valid = req_valid;
            case (mode)
                0: rdy = 1'b1;
                1: rdy = ($urandom % 4) != 0;
                default: rdy = 1'b0;
            endcase
            req_ready <= rdy;
            acc = req_valid && rdy;
            if (acc) begin
                last_acc = cyc;
                acc_cnt++;
                if (m_line == LINES - 1) begin
                    m_line = 0;
                    if (m_rank == RANKS - 1) begin
                        int n;
                        m_rank = 0;
                        n = next_up_ch(m_ch, chan_up);
                        exp_pass = (n <= m_ch);
                        m_ch = n;
                    end else m_rank++;
                end else m_line++;
            end else begin
                if (req_valid && !chan_up[m_ch]) skip_t = 1;
                if (!chan_up[m_ch] && chan_up != 2'b00) m_ch = next_up_ch(m_ch, chan_up);
            end
        end
    end

    task automatic wait_acc(input int n);
        while (acc_cnt < n) @(negedge clk);
    endtask

    task automatic count_valid_window(input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (req_valid) hits++;
        end
    endtask

    initial begin
        int hits;
        int saved;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!req_valid && !pass_done, "R2 reset outputs", req_valid, 0);
        chk(pack_ptr(req_chan, req_rank, req_line) == 0, "R2 reset pointer",
            pack_ptr(req_chan, req_rank, req_line), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!req_valid && pack_ptr(req_chan, req_rank, req_line) == 0, "R2 after reset",
            req_valid, 0);
        run = 1;
        // Phase A: steady rate, full passes (R3, R5, R8)
        @(posedge clk); #1 scrub_en = 1'b1;
        wait_acc(20);
        // Phase B: random back pressure (R4)
        mode = 1;
        wait_acc(45);
        // Phase C: channel 1 offline, skipped (R6)
        mode = 0;
        @(posedge clk); #1 chan_up = 2'b01;
        wait_acc(65);
        chk(m_ch == 0, "R6 stays on channel 0", m_ch, 0);
        // Phase D: current channel goes down with a pending request (R7)
        @(posedge clk); #1 chan_up = 2'b11;
        while (!(m_ch == 0 && m_line == 2)) @(negedge clk);
        mode = 2;
        while (!req_valid) @(negedge clk);
        saved = pack_ptr(1, m_rank, m_line);
        @(posedge clk); #1 chan_up = 2'b10;
        @(negedge clk); @(negedge clk);
        chk(!req_valid, "R7 request withdrawn", req_valid, 0);
        mode = 0;
        while (!req_valid) @(negedge clk);
        chk(pack_ptr(req_chan, req_rank, req_line) == saved, "R7 rank/line kept",
            pack_ptr(req_chan, req_rank, req_line), saved);
        @(posedge clk); #1 chan_up = 2'b11;
        wait_acc(acc_cnt + 3);
        // Phase E: all channels down (R9)
        @(posedge clk); #1 chan_up = 2'b00;
        repeat (2) @(negedge clk);
        count_valid_window(3 * INTERVAL, hits);
        chk(hits == 0, "R9 no request when all down", hits, 0);
        skip_t = 1;
        @(posedge clk); #1 chan_up = 2'b11;
        wait_acc(acc_cnt + 3);
        // Phase F: disabled while waiting (R1)
        @(posedge clk); #1 scrub_en = 1'b0;
        repeat (2) @(negedge clk);
        count_valid_window(3 * INTERVAL, hits);
        chk(hits == 0, "R1 no request while disabled", hits, 0);
        skip_t = 1;
        @(posedge clk); #1 scrub_en = 1'b1;
        wait_acc(acc_cnt + 2);
        // Phase G: disabled with a pending request (R1)
        mode = 2;
        while (!req_valid) @(negedge clk);
        @(posedge clk); #1 scrub_en = 1'b0;
        repeat (INTERVAL) @(negedge clk);
        chk(req_valid, "R1 pending request kept", req_valid, 1);
        mode = 0;
        repeat (2) @(negedge clk);
        count_valid_window(3 * INTERVAL, hits);
        chk(hits == 0, "R1 idle after pending accepted", hits, 0);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("[TB] FAIL watchdog actual=%0d expected=%0d", acc_cnt, -1);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule